// File: doc/BRIEF.md
# Predicate Compare and Nullify Unit

This block turns a two-way decision into data instead of control flow. A compare operation takes two signed operands and a condition code. It writes the condition's truth value into one predicate register and the complement of that value into a second predicate register, both in the same cycle. A later instruction names a qualifying predicate. The gate reads that predicate and raises a commit enable only when the predicate is true. Every write-back path of the surrounding pipeline is meant to be ANDed with this enable, so an instruction whose predicate is false is nullified and does not take effect.

The predicate file holds `NPRED` single-bit entries. Entry 0 always reads true, so an instruction qualified on entry 0 always commits. A compare result is registered at the end of its cycle. An instruction presented in the same cycle as the compare also sees the new value, because the read is bypassed from the pending write.

Top module: `pred_nullify_unit`

## Requirements
- R1: After reset every predicate reads false except entry 0, so `pred_bits` equals 1.
- R2: With `cmp_valid` high, the condition on signed operands (code 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal; A is the left operand) is written into entry `cmp_dst_t`, visible on `pred_bits` after the next rising edge.
- R3: The same compare writes the complement of that result into entry `cmp_dst_f`, so the two entries never hold the same value when they differ and are both nonzero.
- R4: Condition codes 6 and 7 evaluate to false, so `cmp_dst_t` receives 0 and `cmp_dst_f` receives 1.
- R5: When `cmp_dst_t` equals `cmp_dst_f`, that entry receives the complemented value.
- R6: Entry 0 always reads true. Writes that name it are ignored, and an instruction qualified on it always commits when valid.
- R7: `ins_commit` is high in the same cycle exactly when `ins_valid` is high and the predicate named by `ins_qp` is true. `ins_pred` shows that predicate value.
- R8: An instruction presented in the same cycle as a compare that writes its qualifying entry sees the newly computed value.
- R9: With `cmp_valid` low, no predicate entry changes.
- R10: With `ins_valid` low, `ins_commit` is low whatever the predicate value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | A compare is issued this cycle |
| cmp_cond | input | 3 | Condition code |
| cmp_a | input | DW | Signed left operand |
| cmp_b | input | DW | Signed right operand |
| cmp_dst_t | input | IW | Entry receiving the condition result |
| cmp_dst_f | input | IW | Entry receiving the complement |
| ins_valid | input | 1 | An instruction is presented for qualification |
| ins_qp | input | IW | Qualifying predicate index |
| ins_pred | output | 1 | Value of the qualifying predicate, bypassed |
| ins_commit | output | 1 | Commit enable for the instruction's write-back |
| pred_bits | output | NPRED | Registered contents of the predicate file |

## Verification
Directed compares try each condition code with equal operands, with a negative left operand against a positive right one, and with reserved codes. A mix of sign and equality tells signed from unsigned ordering and strict from non-strict conditions. Corner patterns aim at the same cycle bypass for both the true and the complement entry, a compare with both destinations the same, writes aimed at entry 0, and idle compare or instruction inputs, each of which separates one priority or masking rule from its plausible alternatives. A long run of random compares and qualifying indices, with operands often forced equal, then compares every cycle's commit and the whole predicate file against a bench model.

// File: rtl/pred_pkg.sv
package pred_pkg;

    typedef enum logic [2:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_LT = 3'd2,
        CC_LE = 3'd3,
        CC_GT = 3'd4,
        CC_GE = 3'd5
    } cc_e;

endpackage

// File: rtl/pred_cmp.sv
module pred_cmp #(
    parameter int DW = 64
) (
    input  logic [2:0]    cond,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          res
);
    import pred_pkg::*;

    logic sa_eq;
    logic sa_lt;

    always_comb begin
        sa_eq = (a == b);
        sa_lt = ($signed(a) < $signed(b));
    end

    always_comb begin
        unique case (cond)
            CC_EQ:   res = sa_eq;
            CC_NE:   res = !sa_eq;
            CC_LT:   res = sa_lt;
            CC_LE:   res = sa_lt || sa_eq;
            CC_GT:   res = !(sa_lt || sa_eq);
            CC_GE:   res = !sa_lt;
            default: res = 1'b0;
        endcase
    end

endmodule

// File: rtl/pred_file.sv
module pred_file #(
    parameter int NPRED = 64,
    localparam int IW = $clog2(NPRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_t,
    input  logic [IW-1:0]    wr_f,
    input  logic             wr_val,
    input  logic [IW-1:0]    rd_idx,
    output logic             rd_val,
    output logic [NPRED-1:0] pred_q
);
    logic [NPRED-1:0] pred_d;

    // Next contents; complement is applied second so it wins on equal indices.
    always_comb begin
        pred_d = pred_q;
        if (wr_en) begin
            pred_d[wr_t] = wr_val;
            pred_d[wr_f] = !wr_val;
        end
        pred_d[0] = 1'b1;
    end

    generate
        for (genvar gi = 0; gi < NPRED; gi++) begin : g_ent
            if (gi == 0) begin : g_hard
                assign pred_q[gi] = 1'b1;
            end else begin : g_reg
                always_ff @(posedge clk) begin
                    if (!rst_n) pred_q[gi] <= 1'b0;
                    else        pred_q[gi] <= pred_d[gi];
                end
            end
        end
    endgenerate

    // Bypassed read: a same-cycle write is visible to the reader.
    assign rd_val = pred_d[rd_idx];

    assert_pair_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_t != wr_f && wr_t != '0 && wr_f != '0)
        |=> (pred_q[$past(wr_t)] != pred_q[$past(wr_f)]));

    assert_same_dst_inverted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_t == wr_f && wr_f != '0)
        |=> (pred_q[$past(wr_f)] == !$past(wr_val)));

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pred_q));

endmodule

// File: rtl/pred_gate.sv
module pred_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ins_valid,
    input  logic qp_val,
    output logic commit
);
    assign commit = ins_valid && qp_val;

    assert_no_commit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> !commit);

    assert_commit_needs_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> qp_val);

endmodule

// File: rtl/pred_nullify_unit.sv
module pred_nullify_unit #(
    parameter int NPRED = 64,
    parameter int DW    = 64,
    localparam int IW   = $clog2(NPRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic [2:0]       cmp_cond,
    input  logic [DW-1:0]    cmp_a,
    input  logic [DW-1:0]    cmp_b,
    input  logic [IW-1:0]    cmp_dst_t,
    input  logic [IW-1:0]    cmp_dst_f,
    input  logic             ins_valid,
    input  logic [IW-1:0]    ins_qp,
    output logic             ins_pred,
    output logic             ins_commit,
    output logic [NPRED-1:0] pred_bits
);
    logic cmp_res;

    pred_cmp #(.DW(DW)) u_cmp (
        .cond (cmp_cond),
        .a    (cmp_a),
        .b    (cmp_b),
        .res  (cmp_res)
    );

    pred_file #(.NPRED(NPRED)) u_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmp_valid),
        .wr_t   (cmp_dst_t),
        .wr_f   (cmp_dst_f),
        .wr_val (cmp_res),
        .rd_idx (ins_qp),
        .rd_val (ins_pred),
        .pred_q (pred_bits)
    );

    pred_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .qp_val    (ins_pred),
        .commit    (ins_commit)
    );

    assert_p0_commits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_qp == '0) |-> ins_commit);

    assert_fwd_true_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && ins_qp == cmp_dst_t && cmp_dst_t != cmp_dst_f && ins_qp != '0)
        |-> (ins_pred == cmp_res));

    assert_fwd_false_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && ins_qp == cmp_dst_f && ins_qp != '0)
        |-> (ins_pred == !cmp_res));

endmodule

// File: tb/pred_nullify_unit_test.sv
`timescale 1ns/1ps
module pred_nullify_unit_test;
    localparam int NPRED = 64;
    localparam int DW    = 64;
    localparam int IW    = $clog2(NPRED);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp_valid = 1'b0;
    logic [2:0]       cmp_cond = '0;
    logic [DW-1:0]    cmp_a = '0;
    logic [DW-1:0]    cmp_b = '0;
    logic [IW-1:0]    cmp_dst_t = '0;
    logic [IW-1:0]    cmp_dst_f = '0;
    logic             ins_valid = 1'b0;
    logic [IW-1:0]    ins_qp = '0;
    logic             ins_pred;
    logic             ins_commit;
    logic [NPRED-1:0] pred_bits;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [NPRED-1:0] model;

    always #5 clk = ~clk;

    pred_nullify_unit #(.NPRED(NPRED), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_cond(cmp_cond), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
        .ins_valid(ins_valid), .ins_qp(ins_qp),
        .ins_pred(ins_pred), .ins_commit(ins_commit), .pred_bits(pred_bits)
    );

    function automatic bit ref_cmp(input logic [2:0] cc, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (cc)
            3'd0: return $signed(a) == $signed(b);
            3'd1: return $signed(a) != $signed(b);
            3'd2: return $signed(a) <  $signed(b);
            3'd3: return $signed(a) <= $signed(b);
            3'd4: return $signed(a) >  $signed(b);
            3'd5: return $signed(a) >= $signed(b);
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [NPRED-1:0] act, input logic [NPRED-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, check commit before the edge, update model, check file after it.
    task automatic cyc(input bit cv, input logic [2:0] cc, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [IW-1:0] t, input logic [IW-1:0] f,
                       input bit iv, input logic [IW-1:0] qp, input string tag);
        bit res;
        bit pv;
        bit exp_c;
        cmp_valid = cv; cmp_cond = cc; cmp_a = a; cmp_b = b;
        cmp_dst_t = t; cmp_dst_f = f; ins_valid = iv; ins_qp = qp;
        res = ref_cmp(cc, a, b);
        pv = model[qp];
        if (cv && qp == t) pv = res;
        if (cv && qp == f) pv = !res;
        if (qp == '0) pv = 1'b1;
        exp_c = iv && pv;
        #1;
        chk(ins_commit == exp_c && ins_pred == pv, tag, {ins_pred, ins_commit}, {pv, exp_c});
        @(posedge clk);
        if (cv) begin
            model[t] = res;
            model[f] = !res;
        end
        model[0] = 1'b1;
        @(negedge clk);
        chk(pred_bits == model, tag, pred_bits, model);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model = '0;
        model[0] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pred_bits == 64'h1, "R1 reset state", pred_bits, 64'h1);

        // R2 R3 R8: gt, same-cycle read of true and complement entries
        cyc(1, 3'd4, 64'd7, 64'd5, 6'd3, 6'd4, 1, 6'd3, "R2 R8 gt forward true");
        cyc(1, 3'd4, -64'sd3, 64'd2, 6'd3, 6'd4, 1, 6'd4, "R3 R8 gt forward complement");
        // R2 signed ordering
        cyc(1, 3'd2, -64'sd1, 64'd1, 6'd10, 6'd11, 1, 6'd10, "R2 lt signed");
        cyc(1, 3'd0, 64'd9, 64'd9, 6'd12, 6'd13, 1, 6'd12, "R2 eq equal");
        cyc(1, 3'd1, 64'd9, 64'd9, 6'd14, 6'd15, 1, 6'd14, "R2 ne equal");
        cyc(1, 3'd3, 64'd9, 64'd9, 6'd16, 6'd17, 1, 6'd16, "R2 le equal");
        cyc(1, 3'd5, 64'd9, 64'd9, 6'd18, 6'd19, 1, 6'd19, "R2 R3 ge equal");
        cyc(1, 3'd4, 64'd9, 64'd9, 6'd18, 6'd19, 1, 6'd18, "R2 gt equal");
        // R4 reserved codes
        cyc(1, 3'd6, 64'd1, 64'd1, 6'd20, 6'd21, 1, 6'd21, "R4 code6");
        cyc(1, 3'd7, 64'd1, 64'd1, 6'd22, 6'd23, 1, 6'd22, "R4 code7");
        // R5 same destination, complement wins
        cyc(1, 3'd0, 64'd4, 64'd4, 6'd30, 6'd30, 1, 6'd30, "R5 same dst eq");
        cyc(1, 3'd1, 64'd4, 64'd4, 6'd30, 6'd30, 1, 6'd30, "R5 same dst ne");
        // R6 entry 0
        cyc(1, 3'd0, 64'd1, 64'd2, 6'd0, 6'd0, 1, 6'd0, "R6 write p0 ignored");
        cyc(1, 3'd0, 64'd1, 64'd2, 6'd0, 6'd40, 1, 6'd0, "R6 p0 true dst");
        // R9 idle compare
        cyc(0, 3'd1, 64'd1, 64'd2, 6'd3, 6'd4, 1, 6'd3, "R9 idle compare");
        // R10 idle instruction on a true entry
        cyc(0, 3'd0, 64'd0, 64'd0, 6'd0, 6'd0, 0, 6'd0, "R10 idle instr p0");
        cyc(0, 3'd0, 64'd0, 64'd0, 6'd0, 6'd0, 0, 6'd4, "R10 idle instr true entry");
        // R7 read of stored value without forwarding
        cyc(0, 3'd0, 64'd0, 64'd0, 6'd0, 6'd0, 1, 6'd11, "R7 stored false");
        cyc(0, 3'd0, 64'd0, 64'd0, 6'd0, 6'd0, 1, 6'd13, "R7 stored complement");

        for (int i = 0; i < 2000; i++) begin
            logic [DW-1:0] ra;
            logic [DW-1:0] rb;
            ra = {$urandom, $urandom};
            rb = ($urandom_range(0, 3) == 0) ? ra : {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) ra[DW-1] = ~ra[DW-1];
            cyc($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), ra, rb,
                IW'($urandom_range(0, NPRED-1)), IW'($urandom_range(0, 7)),
                $urandom_range(0, 4) != 0, IW'($urandom_range(0, 9)), "R7 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule